// File: doc/BRIEF.md
# Match Timer with Watchdog Channel

This block is a memory-mapped system timer. A single 32-bit up-counter advances by one on every clock cycle in which the tick-enable input is high. Four 32-bit compare registers are checked against the counter on every tick. When a compare hits and that channel is enabled, the block latches a status flag and raises the channel's interrupt line. The interrupt line stays high until software clears the flag by writing a 1 to it.

Compare channel 3 can also serve as a one-shot watchdog. Software arms it by setting bit 0 of the watchdog register. The next hit on channel 3 then emits a single-cycle system reset request and disarms the watchdog.

Software reaches the block through a simple register bus: an address, write data, write and read strobes, and registered read data. The counter can be loaded at any time, and counting continues from the loaded value.

Top module: `match_timer`

## Requirements
- R1: After reset, the counter, all four compare registers, the interrupt enable register and the watchdog register read as zero, every interrupt line is low and the reset request is low.
- R2: Registers are word-aligned at these byte offsets: compare N at 4*N (N = 0..3), counter at 0x10, status at 0x14, watchdog at 0x18, interrupt enable at 0x1C. A read strobe in one cycle presents the addressed value on the read data port from the next cycle onward.
- R3: The counter goes up by one, modulo 2^32, on each cycle with tick enable high. It holds its value otherwise. A write to the counter loads the written value and overrides a tick in the same cycle.
- R4: On a tick where the new counter value equals compare register N and enable bit N is 1, status bit N is set and interrupt line N is high from the next cycle. A counter load never produces a hit. An equality that persists without further ticks does not set the flag again after it is cleared.
- R5: With enable bit N at 0, a hit on channel N leaves status bit N and interrupt line N at 0.
- R6: A write to the status register clears exactly the status bits written as 1 and leaves all others unchanged. Interrupt line N always equals status bit N. The status register reads back the four flags in bits 3:0, with zeros above.
- R7: The interrupt enable register stores only bits 11:0 of a write. Higher bits read back as zero.
- R8: The watchdog register stores only bit 0. If it is 1 on a tick where the counter reaches compare register 3, the reset request is high for exactly one cycle and the watchdog register reads 0 afterwards. This happens whatever the value of enable bit 3. While the watchdog register is 0, no reset request occurs.
- R9: Reads of any offset not listed in R2, including offsets that are not word-aligned, return zero. Writes to such offsets change no register.
- R10: The counter wraps from 0xFFFFFFFF to 0, and a compare value of 0 hits on that wrapping tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advances the counter by one when high |
| busAddr | input | 8 | Byte offset of the register access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt levels |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The properties assume that a bus write and a counter tick in the same cycle resolve in favour of the write. They also assume that tick enable is the only thing that moves the counter. Under those assumptions, every interrupt rise and every reset request can be traced back to a tick in the previous cycle.

The stimulus follows a fixed pattern. Each access is driven on the falling clock edge. Tick enable stays low during register reads, so read-back values do not depend on counting. The single cycle that combines a write with a tick is the one aimed at the override rule.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  parameter int unsigned MT_CHANNELS = 4;
  parameter int unsigned MT_DATA_W   = 32;
  parameter int unsigned MT_ADDR_W   = 8;
  parameter int unsigned MT_IEN_W    = 12;
  parameter int unsigned MT_WDOG_CH  = 3;

  localparam int unsigned MT_CH_IDX_W = $clog2(MT_CHANNELS);

  localparam logic [MT_ADDR_W-1:0] MT_OFS_MATCH0 = 8'h00;
  localparam logic [MT_ADDR_W-1:0] MT_OFS_COUNT  = 8'h10;
  localparam logic [MT_ADDR_W-1:0] MT_OFS_STATUS = 8'h14;
  localparam logic [MT_ADDR_W-1:0] MT_OFS_WDOG   = 8'h18;
  localparam logic [MT_ADDR_W-1:0] MT_OFS_IEN    = 8'h1C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MATCH,
    RD_COUNT,
    RD_STATUS,
    RD_WDOG,
    RD_IEN
  } rdSel_e;

  // Strobes from the decoder to the datapath, one access per cycle.
  typedef struct packed {
    logic [MT_CHANNELS-1:0] wrMatch;
    logic                   wrCount;
    logic                   wrStatus;
    logic                   wrWdog;
    logic                   wrIen;
    logic                   rdStb;
    rdSel_e                 rdSel;
    logic [MT_CH_IDX_W-1:0] rdCh;
  } regStrobe_t;
endpackage

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
#(
  parameter int unsigned NUM_CH = MT_CHANNELS,
  parameter int unsigned ADDR_W = MT_ADDR_W
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobe_t        strobe
);
  localparam int unsigned IDX_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] matchHit;

  // One comparator per compare channel, spaced one word apart.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_match_dec
    assign matchHit[n] = (busAddr == MT_OFS_MATCH0 + ADDR_W'(4 * n));
  end

  logic hitCount, hitStatus, hitWdog, hitIen;
  assign hitCount  = (busAddr == MT_OFS_COUNT);
  assign hitStatus = (busAddr == MT_OFS_STATUS);
  assign hitWdog   = (busAddr == MT_OFS_WDOG);
  assign hitIen    = (busAddr == MT_OFS_IEN);

  always_comb begin
    strobe          = '0;
    strobe.wrMatch  = busWrEn ? matchHit : '0;
    strobe.wrCount  = busWrEn && hitCount;
    strobe.wrStatus = busWrEn && hitStatus;
    strobe.wrWdog   = busWrEn && hitWdog;
    strobe.wrIen    = busWrEn && hitIen;
    strobe.rdStb    = busRdEn;
    strobe.rdSel    = RD_NONE;
    strobe.rdCh     = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (matchHit[n]) begin
        strobe.rdSel = RD_MATCH;
        strobe.rdCh  = IDX_W'(n);
      end
    end
    if (hitCount)  strobe.rdSel = RD_COUNT;
    if (hitStatus) strobe.rdSel = RD_STATUS;
    if (hitWdog)   strobe.rdSel = RD_WDOG;
    if (hitIen)    strobe.rdSel = RD_IEN;
  end
endmodule

// File: rtl/mtmr_datapath.sv
module mtmr_datapath
  import mtmr_pkg::*;
#(
  parameter int unsigned NUM_CH  = MT_CHANNELS,
  parameter int unsigned DATA_W  = MT_DATA_W,
  parameter int unsigned IEN_W   = MT_IEN_W,
  parameter int unsigned WDOG_CH = MT_WDOG_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] busWrData,
  input  regStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] irq,
  output logic              resetReq,
  output logic [DATA_W-1:0] countVal,
  output logic [IEN_W-1:0]  ienVal,
  output logic              wdogArm
);
  logic [DATA_W-1:0] countQ, countNext;
  logic [DATA_W-1:0] matchQ [NUM_CH];
  logic [NUM_CH-1:0] statusQ, matchEq, chanEvent, clrMask;
  logic [IEN_W-1:0]  ienQ;
  logic              wdogArmQ, resetReqQ, tickValid, wdogFire;
  logic [DATA_W-1:0] rdMux;

  // Counter: a bus load wins over a tick in the same cycle.
  assign countNext = countQ + DATA_W'(1);
  assign tickValid = tickEn && !strobe.wrCount;

  always_ff @(posedge clk) begin
    if (!rstN)                countQ <= '0;
    else if (strobe.wrCount)  countQ <= busWrData;
    else if (tickEn)          countQ <= countNext;
  end

  // Compare channels.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                   matchQ[n] <= '0;
      else if (strobe.wrMatch[n])  matchQ[n] <= busWrData;
    end
    assign matchEq[n]   = tickValid && (countNext == matchQ[n]);
    assign chanEvent[n] = matchEq[n] && ienQ[n];
  end

  // Status flags: write-one-to-clear, a new event in the same cycle wins.
  assign clrMask = strobe.wrStatus ? busWrData[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | chanEvent;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ienQ <= '0;
    else if (strobe.wrIen) ienQ <= busWrData[IEN_W-1:0];
  end

  // Watchdog: one-shot, disarmed by its own firing.
  assign wdogFire = matchEq[WDOG_CH] && wdogArmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdogArmQ  <= 1'b0;
      resetReqQ <= 1'b0;
    end else begin
      resetReqQ <= wdogFire;
      if (wdogFire)           wdogArmQ <= 1'b0;
      else if (strobe.wrWdog) wdogArmQ <= busWrData[0];
    end
  end

  // Read path.
  always_comb begin
    unique case (strobe.rdSel)
      RD_MATCH:  rdMux = matchQ[strobe.rdCh];
      RD_COUNT:  rdMux = countQ;
      RD_STATUS: rdMux = DATA_W'(statusQ);
      RD_WDOG:   rdMux = DATA_W'(wdogArmQ);
      RD_IEN:    rdMux = DATA_W'(ienQ);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdData <= '0;
    else if (strobe.rdStb) busRdData <= rdMux;
  end

  assign irq      = statusQ;
  assign resetReq = resetReqQ;
  assign countVal = countQ;
  assign ienVal   = ienQ;
  assign wdogArm  = wdogArmQ;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic [MT_ADDR_W-1:0]   busAddr,
  input  logic [MT_DATA_W-1:0]   busWrData,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  output logic [MT_DATA_W-1:0]   busRdData,
  output logic [MT_CHANNELS-1:0] irq,
  output logic                   resetReq
);
  regStrobe_t             strobe;
  logic [MT_DATA_W-1:0]   countVal;
  logic [MT_IEN_W-1:0]    ienVal;
  logic                   wdogArm;

  mtmr_ctrl #(
    .NUM_CH (MT_CHANNELS),
    .ADDR_W (MT_ADDR_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  mtmr_datapath #(
    .NUM_CH  (MT_CHANNELS),
    .DATA_W  (MT_DATA_W),
    .IEN_W   (MT_IEN_W),
    .WDOG_CH (MT_WDOG_CH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .busRdData (busRdData),
    .irq       (irq),
    .resetReq  (resetReq),
    .countVal  (countVal),
    .ienVal    (ienVal),
    .wdogArm   (wdogArm)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import mtmr_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   tickEn,
  input logic [MT_ADDR_W-1:0]   busAddr,
  input logic [MT_DATA_W-1:0]   busWrData,
  input logic                   busWrEn,
  input logic [MT_CHANNELS-1:0] irq,
  input logic                   resetReq,
  input logic [MT_DATA_W-1:0]   countVal,
  input logic [MT_IEN_W-1:0]    ienVal,
  input logic                   wdogArm
);
  logic cntWr, statWr;
  assign cntWr  = busWrEn && (busAddr == MT_OFS_COUNT);
  assign statWr = busWrEn && (busAddr == MT_OFS_STATUS);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !cntWr |=> countVal == $past(countVal) + MT_DATA_W'(1));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !cntWr |=> $stable(countVal));

  p_count_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> countVal == $past(busWrData));

  for (genvar n = 0; n < MT_CHANNELS; n++) begin : g_irq
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[n]) |-> $past(tickEn) && $past(ienVal[n]) && !$past(cntWr));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      irq[n] && !(statWr && busWrData[n]) |=> irq[n]);
  end

  p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_reset_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(wdogArm) && $past(tickEn) && !wdogArm);
endmodule

bind match_timer match_timer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busWrEn   (busWrEn),
  .irq       (irq),
  .resetReq  (resetReq),
  .countVal  (countVal),
  .ienVal    (ienVal),
  .wdogArm   (wdogArm)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [3:0]  irq;
  logic        resetReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [7:0]  addr;
    string       tag;
  } rdItem_t;
  rdItem_t expQ[$];
  logic rdSeen = 1'b0;

  always #2 clk = ~clk;

  match_timer uut (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .irq       (irq),
    .resetReq  (resetReq)
  );

  // Monitor: a read strobe seen at an edge yields data checked at the next falling edge.
  always @(posedge clk) rdSeen <= busRdEn;

  always @(negedge clk) begin
    if (rdSeen) begin
      rdItem_t it;
      it = expQ.pop_front();
      checks++;
      if (busRdData !== it.exp) begin
        errors++;
        $display("FAIL %s: read 0x%02h actual 0x%08h expected 0x%08h",
                 it.tag, it.addr, busRdData, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rdItem_t it;
    @(negedge clk);
    it.exp = e; it.addr = a; it.tag = tag;
    expQ.push_back(it);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, e);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(32'(irq), 0, "R1 irq");
    chk(32'(resetReq), 0, "R1 resetReq");
    for (int n = 0; n < 4; n++) rd(8'(4 * n), 0, "R1 compare");
    rd(8'h10, 0, "R1 counter");
    rd(8'h18, 0, "R1 watchdog");
    rd(8'h1C, 0, "R1 enable");
    rd(8'h14, 0, "R1 status");

    // R2 register map read-back
    for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'hA000_0000 + 32'(n));
    for (int n = 0; n < 4; n++) rd(8'(4 * n), 32'hA000_0000 + 32'(n), "R2 compare");

    // R3 counting, holding, loading, load over tick
    wr(8'h10, 32'd100);
    tick(5);
    rd(8'h10, 32'd105, "R3 count");
    repeat (4) @(negedge clk);
    rd(8'h10, 32'd105, "R3 hold");
    @(negedge clk);
    busAddr = 8'h10; busWrData = 32'd500; busWrEn = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; tickEn = 1'b0;
    rd(8'h10, 32'd500, "R3 load wins");

    // R4 hit sets flag and line
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'd10);
    wr(8'h10, 32'd7);
    tick(2);
    chk(32'(irq), 0, "R4 before hit");
    tick(1);
    chk(32'(irq), 32'h1, "R4 hit");
    repeat (3) @(negedge clk);
    chk(32'(irq), 32'h1, "R4 level held");
    rd(8'h14, 32'h1, "R4 status");
    wr(8'h14, 32'h1);
    chk(32'(irq), 0, "R6 cleared");
    repeat (3) @(negedge clk);
    chk(32'(irq), 0, "R4 no retrigger");
    wr(8'h10, 32'd10);
    @(negedge clk);
    chk(32'(irq), 0, "R4 load no hit");

    // R5 disabled channel
    wr(8'h04, 32'd20);
    wr(8'h10, 32'd18);
    tick(2);
    chk(32'(irq), 0, "R5 irq");
    rd(8'h14, 0, "R5 status");

    // R6 selective clear
    wr(8'h1C, 32'h5);
    wr(8'h00, 32'd50);
    wr(8'h08, 32'd52);
    wr(8'h10, 32'd49);
    tick(3);
    chk(32'(irq), 32'h5, "R6 two flags");
    wr(8'h14, 32'h4);
    chk(32'(irq), 32'h1, "R6 one cleared");
    wr(8'h14, 32'hFFFF_FFFA);
    rd(8'h14, 32'h1, "R6 zero bits kept");
    wr(8'h14, 32'h1);

    // R7 enable width
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0000_0FFF, "R7 enable");
    wr(8'h1C, 32'h0);

    // R8 watchdog
    wr(8'h0C, 32'd200);
    wr(8'h10, 32'd198);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h1, "R8 arm read");
    tick(1);
    chk(32'(resetReq), 0, "R8 before hit");
    tick(1);
    chk(32'(resetReq), 1, "R8 pulse");
    @(negedge clk);
    chk(32'(resetReq), 0, "R8 single cycle");
    rd(8'h18, 0, "R8 disarmed");
    rd(8'h14, 0, "R8 enable off no flag");
    wr(8'h10, 32'd198);
    tick(2);
    chk(32'(resetReq), 0, "R8 unarmed");

    // R9 unmapped offsets
    drain();
    rd(8'h20, 0, "R9 unmapped read");
    rd(8'h0B, 0, "R9 unaligned read");
    wr(8'h0B, 32'h1234_5678);
    wr(8'h24, 32'h1234_5678);
    rd(8'h08, 32'd52, "R9 write ignored");
    rd(8'h10, 32'd200, "R9 counter kept");

    // R10 wrap
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    tick(1);
    chk(32'(irq), 32'h1, "R10 hit at zero");
    rd(8'h10, 32'h0, "R10 wrapped");

    drain();
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule